// File: doc/BRIEF.md
# I2C Control Slave for a Supply Regulator

This block lets a host processor configure a power-supply control chip over a two-wire I2C bus. It responds to a 7-bit slave address. The upper five bits of that address are fixed. The lower two come from two strap pins, so four such chips can share one bus. Every data byte the host writes carries its own destination: the three most significant bits name one of the system registers, and the five low bits are the payload.

A read transfer returns the status byte, whose low five bits are live fault flags. The host may read as many bytes as it wants and ends by withholding its acknowledge.

SCL and SDA reach the block as ordinary inputs. Each one is resynchronised and glitch-filtered in the system clock domain, and SDA is driven back as an open-drain pull-down enable. A power-good input gates the whole interface. While power-good is low, the slave lets the bus float and never acknowledges, and every register reads zero. The register fields and a per-register write strobe are brought out to the regulator logic.

Top module: `pwrctl_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its seven upper bits equal 0,0,0,1,0 followed by addr_strap[1] and addr_strap[0]; bit 0 of the address byte is the direction (1 = read). Any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: After a matching write address, every data byte is acknowledged by pulling SDA low during the ninth clock.
- R3: Data bits [7:5] select the register. Code 3 is the control register: bit 4 drives out_en, bit 1 drives out_vtop, bit 0 drives out_vbot. A register keeps its value unless a byte addressed to it is accepted.
- R4: Code 1 is the tone register: bit 4 drives tone_en, bit 3 drives tone_msel, bit 2 drives tone_thr.
- R5: Code 2 is the command register: bit 4 drives cur_dyn, bit 3 drives vsel_pin_en, bits [1:0] drive ilim_sel.
- R6: Bytes with codes 4 to 7 are acknowledged but change no output and raise no strobe.
- R7: A byte with code 0 (status) changes no register field and raises wr_stb[0] only.
- R8: Each accepted byte with code k in 0..3 raises wr_stb[k] for exactly one clock. At most one strobe bit is high at a time.
- R9: A read returns the byte {000, fault_flags}, with fault_flags[4..0] carrying over-temperature, cable fault, over/under-voltage, overload and back-current flags. The first byte is sampled on the SCL fall that ends the address acknowledge. Each further byte is sampled again after a master acknowledge. After a master not-acknowledge, SDA is released.
- R10: While pwr_good is low, no acknowledge is given and every register field and strobe is zero.
- R11: After reset all register fields, strobes and sda_oe are zero.
- R12: A START detected in the middle of a byte abandons that byte and begins a new address reception.
- R13: Any number of data bytes may follow one write address, and each one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication; low gates the interface |
| scl_in | input | 1 | Sampled SCL bus line |
| sda_in | input | 1 | Sampled SDA bus line |
| addr_strap | input | 2 | Address strap pins forming the two address LSBs |
| fault_flags | input | 5 | Live fault flags returned in read bytes |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| out_en | output | 1 | Control register: output enable |
| out_vtop | output | 1 | Control register: upper-range voltage pick |
| out_vbot | output | 1 | Control register: lower-range voltage pick |
| tone_en | output | 1 | Tone register: continuous tone enable |
| tone_msel | output | 1 | Tone register: modulation source select |
| tone_thr | output | 1 | Tone register: detector threshold select |
| cur_dyn | output | 1 | Command register: dynamic current-limit select |
| vsel_pin_en | output | 1 | Command register: voltage-select pin override |
| ilim_sel | output | 2 | Command register: current-limit level |
| wr_stb | output | 4 | One-cycle strobe per register code 0..3 |

## Verification
Two situations are hard to reach from the ports. The first is a START that arrives while the slave is partway through shifting in an address bit. The bench gets there with a bit-level master task that clocks three bits and then issues a fresh START without a STOP. It checks that the following full address is still acknowledged and that its data byte is applied. The second is a read whose bytes must reflect fault flags that change between samples. The bench changes fault_flags after the address acknowledge but before the bytes are clocked out. It expects the old value in the first byte and the new value in the second.

// File: rtl/pwrctl_i2c_pkg.sv
// Shared constants and types for the I2C control slave.
// Assumes: byte-wide transfers, register code in the top bits of each data byte.
package pwrctl_i2c_pkg;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 3;
    localparam int PAY_W     = DATA_W - SEL_W;
    localparam int NREG      = 4;
    localparam int STRAP_W   = 2;
    localparam int ADDR_HI_W = 7 - STRAP_W;
    localparam logic [ADDR_HI_W-1:0] ADDR_HI = 5'b00010;
    localparam int FLAG_W    = 5;

    localparam int SEL_STATUS = 0;
    localparam int SEL_TONE   = 1;
    localparam int SEL_CMD    = 2;
    localparam int SEL_CTRL   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } link_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Resynchronises W asynchronous bus lines and removes single-sample glitches.
// Assumes: idle level of every line is high; output changes only after two
// consecutive synchronised samples agree.
module i2c_line_filter #(
    parameter int W     = 2,
    parameter int SYNC  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar gi = 0; gi < W; gi++) begin : g_line
        logic [SYNC-1:0] sync_q;
        logic            prev_q;
        logic            filt_q;

        // Synchronise, remember one sample, and accept a level only once it has held for two samples.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_q <= '1;
                prev_q <= 1'b1;
                filt_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC-2:0], din[gi]};
                prev_q <= sync_q[SYNC-1];
                if (sync_q[SYNC-1] == prev_q) filt_q <= prev_q;
            end
        end

        assign dout[gi] = filt_q;
    end
endmodule

// File: rtl/i2c_link_engine.sv
// Bit and byte sequencer for the slave side of the bus.
// Assumes: filtered SCL/SDA inputs; slave changes SDA only after it sees SCL fall;
// no clock stretching. Produces a write pulse per accepted data byte.
module i2c_link_engine
    import pwrctl_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic               scl,
    input  logic               sda,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [DATA_W-1:0]  rd_byte,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [DATA_W-1:0]  wr_byte
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    link_state_t       state;
    logic              scl_d, sda_d;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] tx;
    logic              done, rw, mack;
    logic              start_det, stop_det, scl_rise, scl_fall;
    logic              addr_hit;

    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign addr_hit  = (sh[DATA_W-1:1] == {ADDR_HI, addr_strap});

    // Main sequencer: framing, shifting, acknowledge and read-data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            done    <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_byte <= '0;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
            wr_en <= 1'b0;
            if (!pwr_good) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                done   <= 1'b0;
            end else if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                done   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[DATA_W-2:0], sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) done <= 1'b1;
                        end else if (scl_fall && done) begin
                            done <= 1'b0;
                            if (state == ST_ADDR) begin
                                if (addr_hit) begin
                                    rw     <= sh[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end else begin
                                wr_en   <= 1'b1;
                                wr_byte <= sh;
                                sda_oe  <= 1'b1;
                                state   <= ST_WACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[DATA_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx     <= {tx[DATA_W-2:0], 1'b0};
                                sda_oe <= ~tx[DATA_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda;
                        end else if (scl_fall) begin
                            if (mack) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[DATA_W-1];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Without power the slave must never pull the bus.
    assert_no_ack_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sda_oe);

    // A new START always lets go of SDA so the address can be received.
    assert_start_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && start_det) |=> !sda_oe);

    // Written bytes are only produced while powered.
    assert_write_needs_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(pwr_good));
endmodule

// File: rtl/sysreg_bank.sv
// Holds the writable register payloads and raises per-code write strobes.
// Assumes: code in the top SEL_W bits of the written byte; the status code has
// no writable payload; codes at or above NREG are dropped.
module sysreg_bank
    import pwrctl_i2c_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pwr_good,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_byte,
    output logic [NREG-1:0][PAY_W-1:0] regs_q,
    output logic [NREG-1:0]            wr_stb
);
    logic [SEL_W-1:0] wr_code;
    logic [PAY_W-1:0] wr_pay;
    logic [NREG-1:0]  hit;

    assign wr_code = wr_byte[DATA_W-1 -: SEL_W];
    assign wr_pay  = wr_byte[PAY_W-1:0];

    // Decode which register code the incoming byte addresses.
    always_comb begin
        for (int i = 0; i < NREG; i++) hit[i] = wr_en && (wr_code == SEL_W'(i));
    end

    // Register storage: cleared while unpowered, loaded on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            regs_q <= '0;
            wr_stb <= '0;
        end else begin
            wr_stb <= hit;
            for (int i = 0; i < NREG; i++) begin
                if (hit[i] && i != SEL_STATUS) regs_q[i] <= wr_pay;
            end
        end
    end

    assert_regs_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (regs_q == '0 && wr_stb == '0));

    assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    assert_strobe_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |=> (wr_stb == '0));

    assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_good && !wr_en) |=> $stable(regs_q));

    assert_unknown_code_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code >= SEL_W'(NREG)) |=> (wr_stb == '0));
endmodule

// File: rtl/pwrctl_i2c_slave.sv
// Top of the I2C control slave: line conditioning, link sequencer, register bank.
// Assumes: SCL/SDA arrive asynchronously; SDA is driven open-drain via sda_oe.
module pwrctl_i2c_slave
    import pwrctl_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] addr_strap,
    input  logic [FLAG_W-1:0]  fault_flags,
    output logic               sda_oe,
    output logic               out_en,
    output logic               out_vtop,
    output logic               out_vbot,
    output logic               tone_en,
    output logic               tone_msel,
    output logic               tone_thr,
    output logic               cur_dyn,
    output logic               vsel_pin_en,
    output logic [1:0]         ilim_sel,
    output logic [NREG-1:0]    wr_stb
);
    logic [1:0]                 lines_f;
    logic                       wr_en;
    logic [DATA_W-1:0]          wr_byte;
    logic [DATA_W-1:0]          rd_byte;
    logic [NREG-1:0][PAY_W-1:0] regs_q;
    logic                       unused_bits;

    assign rd_byte = {{(DATA_W-FLAG_W){1'b0}}, fault_flags};

    i2c_line_filter #(.W(2), .SYNC(2)) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_f)
    );

    i2c_link_engine u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .scl       (lines_f[1]),
        .sda       (lines_f[0]),
        .addr_strap(addr_strap),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte)
    );

    sysreg_bank u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_good(pwr_good),
        .wr_en   (wr_en),
        .wr_byte (wr_byte),
        .regs_q  (regs_q),
        .wr_stb  (wr_stb)
    );

    assign out_en      = regs_q[SEL_CTRL][4];
    assign out_vtop    = regs_q[SEL_CTRL][1];
    assign out_vbot    = regs_q[SEL_CTRL][0];
    assign tone_en     = regs_q[SEL_TONE][4];
    assign tone_msel   = regs_q[SEL_TONE][3];
    assign tone_thr    = regs_q[SEL_TONE][2];
    assign cur_dyn     = regs_q[SEL_CMD][4];
    assign vsel_pin_en = regs_q[SEL_CMD][3];
    assign ilim_sel    = regs_q[SEL_CMD][1:0];

    assign unused_bits = ^{regs_q[SEL_STATUS], regs_q[SEL_CTRL][3:2],
                           regs_q[SEL_TONE][1:0], regs_q[SEL_CMD][2]};
endmodule

// File: tb/pwrctl_i2c_slave_tb.sv
// Directed bench: a bit-level bus master, one task per scenario.
module pwrctl_i2c_slave_tb;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [4:0] flags = '0;
    logic       sda_oe, out_en, out_vtop, out_vbot, tone_en, tone_msel, tone_thr;
    logic       cur_dyn, vsel_pin_en;
    logic [1:0] ilim_sel;
    logic [3:0] wr_stb;
    logic       sda_line;
    int         n_tests = 0;
    int         n_fail = 0;
    int         stb_cnt [4];
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    pwrctl_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .scl_in(scl_m), .sda_in(sda_line),
        .addr_strap(strap), .fault_flags(flags), .sda_oe(sda_oe),
        .out_en(out_en), .out_vtop(out_vtop), .out_vbot(out_vbot),
        .tone_en(tone_en), .tone_msel(tone_msel), .tone_thr(tone_thr),
        .cur_dyn(cur_dyn), .vsel_pin_en(vsel_pin_en), .ilim_sel(ilim_sel), .wr_stb(wr_stb)
    );

    initial for (int k = 0; k < 4; k++) stb_cnt[k] = 0;

    // Count strobe pulses seen at the port.
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) if (wr_stb[k]) stb_cnt[k] = stb_cnt[k] + 1;
    end

    function automatic logic [9:0] outs();
        return {out_en, out_vtop, out_vbot, tone_en, tone_msel, tone_thr,
                cur_dyn, vsel_pin_en, ilim_sel};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(2);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic write_regs(input logic [7:0] b0, input int nb,
                              input logic [7:0] b1, input logic [7:0] b2, input string req);
        bit ack;
        bus_start();
        put_byte(8'h14, ack);
        check(ack, "R1 write address ack", ack, 1);
        put_byte(b0, ack);
        check(ack, req, ack, 1);
        if (nb > 1) begin put_byte(b1, ack); check(ack, req, ack, 1); end
        if (nb > 2) begin put_byte(b2, ack); check(ack, req, ack, 1); end
        bus_stop();
    endtask

    task automatic t_reset();
        check(outs() == 10'h0, "R11 fields zero", outs(), 0);
        check(sda_oe == 1'b0 && wr_stb == 4'h0, "R11 bus released", {sda_oe, wr_stb}, 0);
    endtask

    task automatic t_address();
        bit ack;
        bus_start(); put_byte(8'h10, ack); bus_stop();
        check(!ack, "R1 foreign address nack", ack, 0);
        bus_start(); put_byte(8'h14, ack); bus_stop();
        check(ack, "R1 strap 10 address ack", ack, 1);
        strap = 2'b01; wq();
        bus_start(); put_byte(8'h12, ack); bus_stop();
        check(ack, "R1 strap 01 address ack", ack, 1);
        bus_start(); put_byte(8'h14, ack); bus_stop();
        check(!ack, "R1 old address nack", ack, 0);
        strap = 2'b10; wq();
    endtask

    task automatic t_control();
        int s3 = stb_cnt[3];
        write_regs(8'h73, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h380, "R3 control all set", outs(), 'h380);
        write_regs(8'h71, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h280, "R3 control vtop clear", outs(), 'h280);
        check(stb_cnt[3] - s3 == 2, "R8 control strobes", stb_cnt[3] - s3, 2);
    endtask

    task automatic t_tone();
        write_regs(8'h3C, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h2F0, "R4 tone all set", outs(), 'h2F0);
        write_regs(8'h28, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h2A0, "R4 tone msel only", outs(), 'h2A0);
    endtask

    task automatic t_command();
        int s2 = stb_cnt[2];
        write_regs(8'h5B, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h2AF, "R5 command fields", outs(), 'h2AF);
        check(stb_cnt[2] - s2 == 1, "R8 command strobe", stb_cnt[2] - s2, 1);
    endtask

    task automatic t_unknown();
        int tot = stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3];
        write_regs(8'h9F, 2, 8'hFF, 8'h00, "R6 unknown code ack");
        check(outs() == 10'h2AF, "R6 fields unchanged", outs(), 'h2AF);
        check(stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3] == tot, "R6 no strobe",
              stb_cnt[0] + stb_cnt[1] + stb_cnt[2] + stb_cnt[3], tot);
    endtask

    task automatic t_status();
        int s0 = stb_cnt[0];
        int oth = stb_cnt[1] + stb_cnt[2] + stb_cnt[3];
        write_regs(8'h1F, 1, 8'h00, 8'h00, "R2 data ack");
        check(outs() == 10'h2AF, "R7 status write no field change", outs(), 'h2AF);
        check(stb_cnt[0] - s0 == 1, "R7 status strobe", stb_cnt[0] - s0, 1);
        check(stb_cnt[1] + stb_cnt[2] + stb_cnt[3] == oth, "R7 other strobes idle",
              stb_cnt[1] + stb_cnt[2] + stb_cnt[3], oth);
    endtask

    task automatic t_multi();
        write_regs(8'h72, 3, 8'h24, 8'h42, "R13 multi byte ack");
        check(outs() == 10'h312, "R13 all three applied", outs(), 'h312);
    endtask

    task automatic t_read();
        bit ack;
        logic [7:0] d0, d1;
        flags = 5'b10110;
        bus_start();
        put_byte(8'h15, ack);
        check(ack, "R1 read address ack", ack, 1);
        flags = 5'b01001;
        get_byte(d0, 1'b1);
        get_byte(d1, 1'b0);
        check(d0 == 8'h16, "R9 first byte snapshot", d0, 'h16);
        check(d1 == 8'h09, "R9 second byte resampled", d1, 'h09);
        check(!sda_oe, "R9 released after nack", sda_oe, 0);
        bus_stop();
        check(outs() == 10'h312, "R9 read leaves fields", outs(), 'h312);
    endtask

    task automatic t_restart();
        bit ack;
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(8'h14, ack);
        check(ack, "R12 address after restart ack", ack, 1);
        put_byte(8'h70, ack);
        bus_stop();
        check(outs() == 10'h212, "R12 write after restart", outs(), 'h212);
    endtask

    task automatic t_power();
        bit ack;
        pwr_good = 1'b0; wq(2);
        check(outs() == 10'h0, "R10 fields cleared", outs(), 0);
        bus_start(); put_byte(8'h14, ack); bus_stop();
        check(!ack, "R10 no ack unpowered", ack, 0);
        check(wr_stb == 4'h0, "R10 strobes zero", wr_stb, 0);
        pwr_good = 1'b1; wq(2);
        bus_start(); put_byte(8'h14, ack); bus_stop();
        check(ack, "R10 ack after power back", ack, 1);
        check(outs() == 10'h0, "R10 fields stay zero", outs(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq(2);
        t_reset();
        t_address();
        t_control();
        t_tone();
        t_command();
        t_unknown();
        t_status();
        t_multi();
        t_read();
        t_restart();
        t_power();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule